// File: doc/BRIEF.md
# Per-Round Encoding Mask Generator

This block supplies the XOR mask bits for a table-based cipher datapath in which every 4-bit table is wrapped in input and output encodings that change at every round. The datapath has five layers of tables. Its 32 nibble positions are grouped into eight bundles, and bundle `b` holds nibbles `b`, `b+8`, `b+16` and `b+24`. Each layer takes one random bit per bundle, so one 40-bit word covers all layers.

The external random source is read only once per encryption. When a pulse on `start` coincides with a valid seed, the seed is loaded. Each round-advance strobe after that passes every byte of the word through a nonlinear substitution box. The box is inversion in GF(2^8) modulo x^8+x^4+x^3+x+1, followed by the usual affine map with constant 0x63. This lets the bit pattern keep changing from round to round without a fast random source. The word advances 17 times per encryption: 16 rounds plus the closing step. A padding stage spreads each bundle bit across a full 4-bit mask for every nibble of that bundle, in every layer.

The XOR encoding is an involution. A table's output encoding and the next table's input encoding therefore use the same value, and one mask value per layer boundary serves both.

Top module: `mrf_round_mask`

## Requirements
- R1: After reset the internal word is zero, every mask bit is 0, and both `active` and `seed_missing` are low.
- R2: A `start` pulse with `seed_valid` high loads `seed_data` into the word. On the following cycle the masks reflect the seed and `active` is high.
- R3: Each `step` pulse while `active` is high and `start` is low replaces every byte of the word with its substitution. The substitution is the GF(2^8) inverse (0 maps to 0), then the affine map with constant 0x63. Examples: 0x00 gives 0x63, 0x01 gives 0x7C, 0x53 gives 0xED.
- R4: Exactly 17 advances follow a load. `active` falls with the 17th advance, and any later `step` leaves the word unchanged.
- R5: Mask bit `L*128 + n*4 + j` equals word bit `L*8 + (n mod 8)`, for layer L (0..4), nibble n (0..31) and bit j (0..3). Every 4-bit mask is therefore 0x0 or 0xF.
- R6: A `start` pulse with `seed_valid` low sets `seed_missing`, clears `active`, and keeps the word unchanged. `step` pulses that follow have no effect.
- R7: A later `start` with a valid seed clears `seed_missing`.
- R8: `start` overrides `step` in the same cycle. A `start` in the middle of an encryption reloads the word from the new seed and restarts the count of 17.
- R9: A `step` pulse while `active` is low leaves the masks unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| seed_valid | input | 1 | A seed is present on `seed_data` |
| seed_data | input | 40 | Random seed, one bit per layer and bundle |
| start | input | 1 | Begin an encryption; loads the seed |
| step | input | 1 | Round-advance strobe |
| mask | output | 640 | Padded 4-bit XOR masks: 5 layers of 32 nibbles |
| active | output | 1 | Word is inside its 17-step sequence |
| seed_missing | output | 1 | Last `start` found no valid seed |

## Verification
The hardest case to reach is the boundary after the seventeenth advance. Another 17-step sequence must reach the exact word the independent model predicts, and the next strobe must leave that word untouched. The bench drives full sequences for several seeds and checks every intermediate mask. It then issues extra strobes after the count has run out. It also restarts in the middle of a sequence, with `start` and `step` high in the same cycle, to show that the count resets. A seed of 0x0000000001 places both the zero byte and the one byte in the substitution at once, which pins down known substitution values.

// File: rtl/mrf_pkg.sv
package mrf_pkg;
    localparam int DEF_LAYERS          = 5;
    localparam int DEF_BUNDLES         = 8;
    localparam int DEF_NIBS_PER_BUNDLE = 4;
    localparam int DEF_NIB_W           = 4;
    localparam int DEF_NUM_STEPS       = 17;
    localparam int BYTE_W              = 8;
    localparam logic [7:0] GF_POLY_LO  = 8'h1B;
    localparam logic [7:0] AFFINE_C    = 8'h63;

    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = sh[7] ? ((sh << 1) ^ GF_POLY_LO) : (sh << 1);
        end
        return acc;
    endfunction
endpackage

// File: rtl/mrf_sbox.sv
module mrf_sbox
    import mrf_pkg::*;
(
    input  logic [7:0] byte_in,
    output logic [7:0] byte_out
);
    logic [7:0] inv;

    // inverse as byte_in^254 by square-and-multiply (254 = 0b11111110)
    always_comb begin
        logic [7:0] pw;
        pw  = byte_in;
        inv = 8'h01;
        for (int k = 1; k < 8; k++) begin
            pw  = gf_mul(pw, pw);
            inv = gf_mul(inv, pw);
        end
    end

    always_comb begin
        byte_out = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
                 ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ AFFINE_C;
    end

    // R3: the exponent chain really produces a multiplicative inverse
    always_comb begin
        if (!$isunknown(byte_in) && byte_in != 8'h00)
            assert_inverse_R3: assert (gf_mul(byte_in, inv) == 8'h01);
    end
endmodule

// File: rtl/mrf_pad.sv
module mrf_pad #(
    parameter int LAYERS          = 5,
    parameter int BUNDLES         = 8,
    parameter int NIBS_PER_BUNDLE = 4,
    parameter int NIB_W           = 4
) (
    input  logic [LAYERS*BUNDLES-1:0]                       word_in,
    output logic [LAYERS*BUNDLES*NIBS_PER_BUNDLE*NIB_W-1:0] mask_out
);
    localparam int NIBS    = BUNDLES * NIBS_PER_BUNDLE;
    localparam int LAYER_W = NIBS * NIB_W;

    for (genvar l = 0; l < LAYERS; l++) begin : g_layer
        for (genvar n = 0; n < NIBS; n++) begin : g_nib
            assign mask_out[l*LAYER_W + n*NIB_W +: NIB_W] =
                {NIB_W{word_in[l*BUNDLES + (n % BUNDLES)]}};

            // R5: each padded nibble is all zeros or all ones
            always_comb begin
                if (!$isunknown(mask_out[l*LAYER_W + n*NIB_W +: NIB_W]))
                    assert_nibble_uniform_R5: assert (
                        mask_out[l*LAYER_W + n*NIB_W +: NIB_W] == '0 ||
                        mask_out[l*LAYER_W + n*NIB_W +: NIB_W] == '1);
            end
        end
    end
endmodule

// File: rtl/mrf_round_mask.sv
module mrf_round_mask
    import mrf_pkg::*;
#(
    parameter int LAYERS          = DEF_LAYERS,
    parameter int BUNDLES         = DEF_BUNDLES,
    parameter int NIBS_PER_BUNDLE = DEF_NIBS_PER_BUNDLE,
    parameter int NIB_W           = DEF_NIB_W,
    parameter int NUM_STEPS       = DEF_NUM_STEPS
) (
    input  logic                                            clk,
    input  logic                                            rst_n,
    input  logic                                            seed_valid,
    input  logic [LAYERS*BUNDLES-1:0]                       seed_data,
    input  logic                                            start,
    input  logic                                            step,
    output logic [LAYERS*BUNDLES*NIBS_PER_BUNDLE*NIB_W-1:0] mask,
    output logic                                            active,
    output logic                                            seed_missing
);
    localparam int WORD_W    = LAYERS * BUNDLES;
    localparam int NUM_BOXES = WORD_W / BYTE_W;
    localparam int CNT_W     = $clog2(NUM_STEPS + 1);

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [CNT_W-1:0]  cnt;
        logic              active;
        logic              missing;
    } state_t;

    state_t state_d, state_q;
    logic [WORD_W-1:0] subst_word;

    for (genvar b = 0; b < NUM_BOXES; b++) begin : g_box
        mrf_sbox u_box (
            .byte_in  (state_q.word[b*BYTE_W +: BYTE_W]),
            .byte_out (subst_word[b*BYTE_W +: BYTE_W])
        );
    end

    always_comb begin
        state_d = state_q;
        if (start) begin
            if (seed_valid) begin
                state_d.word    = seed_data;
                state_d.cnt     = '0;
                state_d.active  = 1'b1;
                state_d.missing = 1'b0;
            end else begin
                state_d.missing = 1'b1;
                state_d.active  = 1'b0;
            end
        end else if (step && state_q.active) begin
            state_d.word = subst_word;
            state_d.cnt  = state_q.cnt + CNT_W'(1);
            if (state_q.cnt == CNT_W'(NUM_STEPS - 1))
                state_d.active = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    mrf_pad #(
        .LAYERS          (LAYERS),
        .BUNDLES         (BUNDLES),
        .NIBS_PER_BUNDLE (NIBS_PER_BUNDLE),
        .NIB_W           (NIB_W)
    ) u_pad (
        .word_in  (state_q.word),
        .mask_out (mask)
    );

    assign active       = state_q.active;
    assign seed_missing = state_q.missing;

    assert_seed_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start && seed_valid |=> active && !seed_missing && state_q.word == $past(seed_data));

    // the substitution has no fixed point, so an advance must change every byte
    assert_advance_changes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !start && step && active |=> state_q.word[7:0] != $past(state_q.word[7:0]));

    assert_step_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.cnt <= CNT_W'(NUM_STEPS) && (active -> state_q.cnt < CNT_W'(NUM_STEPS)));

    assert_missing_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start && !seed_valid |=> seed_missing && !active && $stable(state_q.word));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !start && !active |=> $stable(state_q.word));
endmodule

// File: tb/sim_mrf_round_mask.sv
`timescale 1ns/1ps
module sim_mrf_round_mask;
    localparam int WW = 40;
    localparam int MW = 640;
    localparam int STEPS = 17;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic seed_valid = 1'b0;
    logic [WW-1:0] seed_data = '0;
    logic start = 1'b0;
    logic step = 1'b0;
    logic [MW-1:0] mask;
    logic active, seed_missing;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    mrf_round_mask u0 (
        .clk(clk), .rst_n(rst_n), .seed_valid(seed_valid), .seed_data(seed_data),
        .start(start), .step(step), .mask(mask), .active(active),
        .seed_missing(seed_missing)
    );

    function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] r = '0;
        logic [7:0] x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) r ^= x;
            x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1B : 8'h00);
        end
        return r;
    endfunction

    function automatic logic [7:0] m_sbox(input logic [7:0] a);
        logic [7:0] inv = '0;
        logic [7:0] o;
        for (int y = 1; y < 256; y++)
            if (m_mul(a, 8'(y)) == 8'h01) inv = 8'(y);
        for (int i = 0; i < 8; i++)
            o[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8];
        return o ^ 8'h63;
    endfunction

    function automatic logic [WW-1:0] m_adv(input logic [WW-1:0] w);
        logic [WW-1:0] r;
        for (int b = 0; b < 5; b++) r[b*8 +: 8] = m_sbox(w[b*8 +: 8]);
        return r;
    endfunction

    function automatic logic [MW-1:0] m_pad(input logic [WW-1:0] w);
        logic [MW-1:0] m;
        for (int l = 0; l < 5; l++)
            for (int n = 0; n < 32; n++)
                for (int j = 0; j < 4; j++)
                    m[l*128 + n*4 + j] = w[l*8 + (n % 8)];
        return m;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [MW-1:0] act,
                       input logic [MW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_start(input bit v, input logic [WW-1:0] s);
        @(negedge clk);
        seed_valid = v; seed_data = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0; seed_valid = 1'b0;
    endtask

    task automatic do_step();
        @(negedge clk);
        step = 1'b1;
        @(negedge clk);
        step = 1'b0;
    endtask

    task automatic t_reset();
        chk(mask == '0, "R1 mask", mask, '0);
        chk(active == 1'b0 && seed_missing == 1'b0, "R1 flags",
            MW'({active, seed_missing}), '0);
    endtask

    task automatic t_sequence(input logic [WW-1:0] s);
        logic [WW-1:0] w = s;
        do_start(1'b1, s);
        chk(mask == m_pad(w), "R2 seed load", mask, m_pad(w));
        chk(active == 1'b1, "R2 active", MW'(active), MW'(1));
        for (int k = 1; k <= STEPS; k++) begin
            do_step();
            w = m_adv(w);
            chk(mask == m_pad(w), "R3 R5 step mask", mask, m_pad(w));
            chk(active == (k < STEPS), "R4 active", MW'(active), MW'(k < STEPS));
        end
        do_step();
        chk(mask == m_pad(w), "R4 extra step ignored", mask, m_pad(w));
    endtask

    task automatic t_known_sbox();
        // bytes 01,00,00,00,00 -> 7C,63,63,63,63
        logic [WW-1:0] e = {8'h63, 8'h63, 8'h63, 8'h63, 8'h7C};
        do_start(1'b1, 40'h00_00_00_00_01);
        do_step();
        chk(mask == m_pad(e), "R3 known values", mask, m_pad(e));
        do_start(1'b1, 40'h00_00_00_00_53);
        do_step();
        e = {8'h63, 8'h63, 8'h63, 8'h63, 8'hED};
        chk(mask == m_pad(e), "R3 0x53", mask, m_pad(e));
    endtask

    task automatic t_pad_fields();
        do_start(1'b1, 40'h80_00_00_00_01);
        // layer 0 bundle 0 -> nibbles 0,8,16,24; layer 4 bundle 7 -> nibbles 7,15,23,31
        chk(mask[3:0] == 4'hF && mask[35:32] == 4'hF && mask[7:4] == 4'h0,
            "R5 layer0 bundle0", MW'(mask[127:0]), MW'(128'h0000000F_0000000F_0000000F_0000000F));
        chk(mask[639:636] == 4'hF && mask[543:540] == 4'hF && mask[539:512] == '0,
            "R5 layer4 bundle7", MW'(mask[639:512]), MW'(128'hF0000000_F0000000_F0000000_F0000000));
    endtask

    task automatic t_missing();
        logic [WW-1:0] s = 40'hA5_3C_96_0F_E1;
        logic [WW-1:0] hold;
        do_start(1'b1, s);
        do_step();
        hold = m_adv(s);
        do_start(1'b0, 40'hFF_FF_FF_FF_FF);
        chk(seed_missing == 1'b1 && active == 1'b0, "R6 flags",
            MW'({seed_missing, active}), MW'(2'b10));
        chk(mask == m_pad(hold), "R6 word held", mask, m_pad(hold));
        do_step();
        chk(mask == m_pad(hold), "R6 R9 step ignored", mask, m_pad(hold));
        do_start(1'b1, s);
        chk(seed_missing == 1'b0 && mask == m_pad(s), "R7 cleared", mask, m_pad(s));
    endtask

    task automatic t_restart();
        logic [WW-1:0] a = 40'h11_22_33_44_55;
        logic [WW-1:0] b = 40'hDE_AD_BE_EF_42;
        logic [WW-1:0] w;
        do_start(1'b1, a);
        for (int k = 0; k < 10; k++) do_step();
        @(negedge clk);
        start = 1'b1; step = 1'b1; seed_valid = 1'b1; seed_data = b;
        @(negedge clk);
        start = 1'b0; step = 1'b0; seed_valid = 1'b0;
        chk(mask == m_pad(b), "R8 start beats step", mask, m_pad(b));
        w = b;
        for (int k = 1; k <= STEPS; k++) begin
            do_step();
            w = m_adv(w);
        end
        chk(mask == m_pad(w) && active == 1'b0, "R8 full count after restart",
            mask, m_pad(w));
    endtask

    initial begin
        #(10ns * 200000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #12 t_reset();
        rst_n = 1'b1;
        do_step();
        chk(mask == '0, "R9 step before any load", mask, '0);
        t_known_sbox();
        t_pad_fields();
        t_sequence(40'h00_00_00_00_00);
        t_sequence(40'hFF_FF_FF_FF_FF);
        t_sequence(40'h01_23_45_67_89);
        t_sequence(40'h9E_37_79_B9_7F);
        t_missing();
        t_restart();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule